// File: doc/BRIEF.md
# DMA Channel Address Generator

This block keeps the two running addresses of one DMA channel: the address on the peripheral side and the address on the memory side. A load pulse captures both start addresses, a 2-bit width code for each side and the increment-control bits of a 32-bit channel configuration word. After that, each beat-done strobe moves each address forward by its step or leaves it where it is, as the captured bits select.

The peripheral step is normally the peripheral data width. The configuration can instead fix it at 4 bytes, whatever the width. The memory step always equals the memory data width. The surrounding channel logic presents the two outputs on its bus ports and pulses the beat strobe when a transfer completes. The block does no counting of its own.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is asserted, and until the first load after reset, both address outputs read 0.
- R2: The cycle after a load pulse, the peripheral output equals the peripheral start address and the memory output equals the memory start address. A beat strobe in the same cycle as a load has no effect.
- R3: When configuration bit 9 was 0 at the last load, the peripheral address does not change on beats.
- R4: When bit 9 was 1 and bit 15 was 0, each beat adds the peripheral width in bytes. Width code 00 gives 1, 01 gives 2 and 10 gives 4.
- R5: When bit 9 and bit 15 were both 1, each beat adds 4 to the peripheral address for every width code.
- R6: Bit 10 enables the memory increment. When it is 1, each beat adds the memory width in bytes, coded as in R4. When it is 0, the memory address holds. Bit 15 has no effect on the memory step.
- R7: Width code 11 on either side is treated as a 4-byte word.
- R8: In a cycle with neither load nor beat, both addresses hold.
- R9: Addresses wrap modulo 2^32 with no other effect.
- R10: The configuration, the width codes and the start inputs are sampled only on load. Changing them between loads does not change the stepping. Configuration bits other than 9, 10 and 15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_i | input | 1 | Load pulse: capture start addresses and configuration |
| beat_i | input | 1 | Beat-done strobe: advance the addresses |
| cfg_i | input | 32 | Channel configuration word (bits 9, 10 and 15 are used) |
| per_size_i | input | 2 | Peripheral data width code |
| mem_size_i | input | 2 | Memory data width code |
| per_start_i | input | 32 | Peripheral start address |
| mem_start_i | input | 32 | Memory start address |
| per_addr_o | output | 32 | Current peripheral address |
| mem_addr_o | output | 32 | Current memory address |

## Verification
The outputs are registered, so a wrong captured increment bit, fixed-step bit or width code shows up on the first beat after the load. The address then moves one cycle later by a wrong amount, or does not move at all. A load that loses its priority over a beat, or a step taken from the live configuration instead of the captured one, shows up as an offset in that same next cycle. The offset then grows with every further beat. Every check therefore compares an output one cycle after a load or beat, or after a run of beats, so that an error in any single step remains visible.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned CFG_W    = 32;
  localparam int unsigned SIZE_W   = 2;
  localparam int unsigned PINC_BIT = 9;
  localparam int unsigned MINC_BIT = 10;
  localparam int unsigned PFIX_BIT = 15;
  localparam int unsigned FIX_STEP = 4;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } size_e;

  // Width code to byte step; the reserved code counts as a word.
  function automatic logic [ADDR_W-1:0] size_bytes(input size_e sz);
    unique case (sz)
      SZ_BYTE: size_bytes = ADDR_W'(1);
      SZ_HALF: size_bytes = ADDR_W'(2);
      default: size_bytes = ADDR_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/dag_rst_sync.sv
module dag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dag_step.sv
module dag_step
  import dag_pkg::*;
#(
  parameter bit HAS_FIX = 1'b0
) (
  input  logic              inc_en,
  input  logic              fix_en,
  input  size_e             size,
  output logic [ADDR_W-1:0] step
);
  logic [ADDR_W-1:0] width_step;

  assign width_step = size_bytes(size);

  generate
    if (HAS_FIX) begin : g_fix
      always_comb begin
        if (!inc_en)     step = '0;
        else if (fix_en) step = ADDR_W'(FIX_STEP);
        else             step = width_step;
      end
    end else begin : g_nofix
      logic unused_fix;
      assign unused_fix = fix_en;
      always_comb begin
        step = inc_en ? width_step : '0;
      end
    end
  endgenerate
endmodule

// File: rtl/dag_addr_reg.sv
module dag_addr_reg
  import dag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;
  logic              addr_en;

  assign addr_en = load | adv;

  always_comb begin
    if (load) addr_d = start;
    else      addr_d = addr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic        beat_i,
  input  logic [31:0] cfg_i,
  input  logic [1:0]  per_size_i,
  input  logic [1:0]  mem_size_i,
  input  logic [31:0] per_start_i,
  input  logic [31:0] mem_start_i,
  output logic [31:0] per_addr_o,
  output logic [31:0] mem_addr_o
);
  logic              rst_sync_n;
  logic              pinc_q, minc_q, pfix_q;
  size_e             psize_q, msize_q;
  logic              pinc_d, minc_d, pfix_d;
  size_e             psize_d, msize_d;
  logic [ADDR_W-1:0] per_step, mem_step;
  logic              adv;

  dag_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Configuration capture: next-state
  always_comb begin
    pinc_d  = cfg_i[PINC_BIT];
    minc_d  = cfg_i[MINC_BIT];
    pfix_d  = cfg_i[PFIX_BIT];
    psize_d = size_e'(per_size_i);
    msize_d = size_e'(mem_size_i);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pinc_q  <= 1'b0;
      minc_q  <= 1'b0;
      pfix_q  <= 1'b0;
      psize_q <= SZ_BYTE;
      msize_q <= SZ_BYTE;
    end else if (load_i) begin
      pinc_q  <= pinc_d;
      minc_q  <= minc_d;
      pfix_q  <= pfix_d;
      psize_q <= psize_d;
      msize_q <= msize_d;
    end
  end

  dag_step #(.HAS_FIX(1'b1)) per_step_i (
    .inc_en (pinc_q),
    .fix_en (pfix_q),
    .size   (psize_q),
    .step   (per_step)
  );

  dag_step #(.HAS_FIX(1'b0)) mem_step_i (
    .inc_en (minc_q),
    .fix_en (1'b0),
    .size   (msize_q),
    .step   (mem_step)
  );

  assign adv = beat_i & ~load_i;

  dag_addr_reg per_reg_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load_i),
    .adv    (adv),
    .start  (per_start_i),
    .step   (per_step),
    .addr_q (per_addr_o)
  );

  dag_addr_reg mem_reg_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (load_i),
    .adv    (adv),
    .start  (mem_start_i),
    .step   (mem_step),
    .addr_q (mem_addr_o)
  );
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        load_i,
  input logic        beat_i,
  input logic [31:0] per_start_i,
  input logic [31:0] mem_start_i,
  input logic [31:0] per_addr_o,
  input logic [31:0] mem_addr_o,
  input logic        pinc_q,
  input logic        minc_q,
  input logic        pfix_q,
  input logic [1:0]  msize_q
);
  logic [31:0] mem_exp_step;
  assign mem_exp_step = (msize_q == 2'b00) ? 32'd1 : (msize_q == 2'b01) ? 32'd2 : 32'd4;

  // R1
  always @(posedge clk) begin
    if (!rst_sync_n) begin
      reset_zero_chk: assert (per_addr_o == 32'd0 && mem_addr_o == 32'd0);
    end
  end

  // R2
  load_start_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_i |=> (per_addr_o == $past(per_start_i)) && (mem_addr_o == $past(mem_start_i)));

  // R3
  per_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_i && !load_i && !pinc_q) |=> $stable(per_addr_o));

  // R5
  per_fix_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_i && !load_i && pinc_q && pfix_q) |=> (per_addr_o == $past(per_addr_o) + 32'd4));

  // R6
  mem_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_i && !load_i && minc_q) |=> (mem_addr_o == $past(mem_addr_o) + $past(mem_exp_step)));

  // R6
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (beat_i && !load_i && !minc_q) |=> $stable(mem_addr_o));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!beat_i && !load_i) |=> ($stable(per_addr_o) && $stable(mem_addr_o)));
endmodule

bind dma_addr_gen dma_addr_gen_chk chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .load_i      (load_i),
  .beat_i      (beat_i),
  .per_start_i (per_start_i),
  .mem_start_i (mem_start_i),
  .per_addr_o  (per_addr_o),
  .mem_addr_o  (mem_addr_o),
  .pinc_q      (pinc_q),
  .minc_q      (minc_q),
  .pfix_q      (pfix_q),
  .msize_q     (msize_q)
);

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_i, beat_i;
  logic [31:0] cfg_i, per_start_i, mem_start_i;
  logic [1:0]  per_size_i, mem_size_i;
  logic [31:0] per_addr_o, mem_addr_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .beat_i(beat_i), .cfg_i(cfg_i),
    .per_size_i(per_size_i), .mem_size_i(mem_size_i),
    .per_start_i(per_start_i), .mem_start_i(mem_start_i),
    .per_addr_o(per_addr_o), .mem_addr_o(mem_addr_o)
  );

  // cfg, psize, msize, pstart, mstart, beats, exp per, exp mem
  typedef struct packed {
    logic [31:0] cfg;
    logic [1:0]  ps;
    logic [1:0]  ms;
    logic [31:0] pst;
    logic [31:0] mst;
    logic [7:0]  n;
    logic [31:0] ep;
    logic [31:0] em;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0600, 2'd0, 2'd2, 32'h1000, 32'h2000, 8'd3, 32'h1003, 32'h200C}, // R4 R6
    '{32'h0000_0600, 2'd1, 2'd0, 32'h1000, 32'h2000, 8'd4, 32'h1008, 32'h2004}, // R4 R6
    '{32'h0000_8600, 2'd0, 2'd1, 32'h1000, 32'h2000, 8'd2, 32'h1008, 32'h2004}, // R5 R6
    '{32'h0000_0000, 2'd2, 2'd2, 32'h1000, 32'h2000, 8'd5, 32'h1000, 32'h2000}, // R3 R6
    '{32'h0000_0200, 2'd2, 2'd2, 32'h1000, 32'h2000, 8'd2, 32'h1008, 32'h2000}, // R4 R6
    '{32'h0000_0400, 2'd3, 2'd3, 32'h1000, 32'h2000, 8'd3, 32'h1000, 32'h200C}, // R7
    '{32'h0000_0600, 2'd3, 2'd1, 32'hFFFF_FFFC, 32'hFFFF_FFFF, 8'd2, 32'h0000_0004, 32'h0000_0003}, // R9
    '{32'hFFFF_FFFF, 2'd1, 2'd0, 32'h1000, 32'h2000, 8'd1, 32'h1004, 32'h2001}  // R5 R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] c, input logic [1:0] ps, input logic [1:0] ms,
                         input logic [31:0] pst, input logic [31:0] mst);
    @(negedge clk);
    cfg_i = c; per_size_i = ps; mem_size_i = ms;
    per_start_i = pst; mem_start_i = mst;
    load_i = 1'b1; beat_i = 1'b0;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  task automatic do_beats(input int n);
    for (int i = 0; i < n; i++) begin
      beat_i = 1'b1;
      @(negedge clk);
      beat_i = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; load_i = 1'b0; beat_i = 1'b0; cfg_i = '0;
    per_size_i = '0; mem_size_i = '0; per_start_i = '0; mem_start_i = '0;
    repeat (3) @(negedge clk);
    check("R1 per reset", per_addr_o, 32'd0);
    check("R1 mem reset", mem_addr_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    beat_i = 1'b1; @(negedge clk); beat_i = 1'b0; @(negedge clk);
    check("R1 per after release", per_addr_o, 32'd0);
    check("R1 mem after release", mem_addr_o, 32'd0);

    for (int v = 0; v < NV; v++) begin
      do_load(VECS[v].cfg, VECS[v].ps, VECS[v].ms, VECS[v].pst, VECS[v].mst);
      check("R2 per load", per_addr_o, VECS[v].pst);
      check("R2 mem load", mem_addr_o, VECS[v].mst);
      do_beats(int'(VECS[v].n));
      check("R3-7/R9 per vector", per_addr_o, VECS[v].ep);
      check("R3-7/R9 mem vector", mem_addr_o, VECS[v].em);
    end

    // R8: idle cycles hold
    do_load(32'h0000_0600, 2'd2, 2'd2, 32'h4000, 32'h5000);
    do_beats(1);
    repeat (5) @(negedge clk);
    check("R8 per idle", per_addr_o, 32'h4004);
    check("R8 mem idle", mem_addr_o, 32'h5004);

    // R2: load wins over simultaneous beat
    @(negedge clk);
    per_start_i = 32'h7000; mem_start_i = 32'h8000;
    load_i = 1'b1; beat_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0; beat_i = 1'b0;
    check("R2 per load+beat", per_addr_o, 32'h7000);
    check("R2 mem load+beat", mem_addr_o, 32'h8000);

    // R10: inputs changed after load have no effect
    cfg_i = 32'h0000_0000; per_size_i = 2'd0; mem_size_i = 2'd0;
    per_start_i = 32'hDEAD_0000; mem_start_i = 32'hBEEF_0000;
    do_beats(2);
    check("R10 per live cfg ignored", per_addr_o, 32'h7008);
    check("R10 mem live cfg ignored", mem_addr_o, 32'h8008);

    // R5: fixed step with byte width, memory unaffected by bit 15
    do_load(32'h0000_8600, 2'd0, 2'd0, 32'h100, 32'h200);
    do_beats(3);
    check("R5 per fixed step", per_addr_o, 32'h10C);
    check("R6 mem ignores bit15", mem_addr_o, 32'h203);

    // R9: memory wrap with word step
    do_load(32'h0000_0400, 2'd0, 2'd2, 32'h0, 32'hFFFF_FFF8);
    do_beats(3);
    check("R9 mem wrap", mem_addr_o, 32'h0000_0004);
    check("R3 per held", per_addr_o, 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule